// File: doc/BRIEF.md
# NOR Flash Command State Machine

This block is the device side of a byte-wide NOR flash command interface. It watches the write strobe for the software unlock cycles that guard the array and only changes stored data after a complete, uninterrupted sequence. Two operations exist. Single-byte program needs three unlock writes followed by one write that carries the target address and data. Sector erase needs five unlock writes followed by a confirm byte written to any address inside the sector to be cleared. Every programmed byte needs its own full unlock; there is no burst mode.

While an operation is in progress, the block reports status through bit 7 of read data. During a program, bit 7 reads as the inverse of the bit being written. During an erase, reads return zero. Program and erase durations are parameters counted in clock cycles. Erase rewrites the sector one byte per cycle, so its busy window is never shorter than the sector size. The storage is a small parameterised array. Address bits above the array width alias onto it.

Top module: `nor_flash_cmd`

## Requirements
- R1: Writing 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555, then data D to address X programs X; no other write pattern ever changes a stored byte except the erase sequence.
- R2: A program leaves the stored byte equal to its old value ANDed with D, so program can clear bits but never set them.
- R3: Writing 0xAA/0x5555, 0x55/0x2AAA, 0x80/0x5555, 0xAA/0x5555, 0x55/0x2AAA, then 0x30 to address X sets every byte of the 4 KB sector holding X to 0xFF. The sector is taken from address bits [MEM_AW-1:12], and bytes in other sectors keep their values.
- R4: Address bits 11:0 of the erase confirm write do not affect which bytes are erased.
- R5: A read issued while a sequence is partly entered (any state short of busy) cancels it, so a following data write does not program.
- R6: A write that does not match the next expected unlock or command cycle returns the machine to idle, and that write is itself not taken as a first unlock cycle.
- R7: Unlock matching compares only address bits 14:0 against 0x5555 and 0x2AAA; upper address bits may hold any value.
- R8: For PROG_CYC cycles after the data write of a program, reads return {~D[7], 7'b0000000}. The read issued in cycle PROG_CYC+1 returns the stored value.
- R9: For max(ERASE_CYC, 4096) cycles after the confirm write, reads return 0x00. The read issued in the cycle after that returns stored data.
- R10: While a program or erase is busy, writes are ignored. This holds even for a full unlock sequence plus data, which leaves its target unchanged.
- R11: After a program completes, a further write without a new unlock sequence does not program.
- R12: After reset, read data is 0x00 and the machine is idle.
- R13: Read data is registered. A read sampled at a clock edge updates the output at that edge, and the output holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W (19) | Byte address for reads and writes |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; takes priority over wr_en |
| rdata | output | 8 | Registered read data or busy status |

## Verification
The hardest condition to reach is the exact last cycle of a busy window. That is the one cycle where status still shows before true data returns. For erase, this is thousands of cycles after a six-write sequence. The stimulus counts idle cycles from the confirm write, so that one read lands in the final busy cycle and the next read in the first free cycle. This is done for both program and erase.

Aborts are reached by issuing reads or wrong writes after one, two and three correct unlock cycles. A data write follows each abort, and the result shows whether any stale sequence state survived.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_U1,
        ST_U2,
        ST_PGM_ARM,
        ST_E3,
        ST_E4,
        ST_E5,
        ST_PGM_BUSY,
        ST_ERS_BUSY
    } nfc_state_e;

    localparam logic [14:0] UNLOCK_ADDR_A = 15'h5555;
    localparam logic [14:0] UNLOCK_ADDR_B = 15'h2AAA;
    localparam logic [7:0]  KEY_FIRST     = 8'hAA;
    localparam logic [7:0]  KEY_SECOND    = 8'h55;
    localparam logic [7:0]  OP_PROGRAM    = 8'hA0;
    localparam logic [7:0]  OP_ERASE      = 8'h80;
    localparam logic [7:0]  OP_SECT_CONF  = 8'h30;

endpackage

// File: rtl/nfc_unlock_decode.sv
module nfc_unlock_decode
    import nfc_pkg::*;
#(
    parameter int MATCH_W = 15
) (
    input  logic [MATCH_W-1:0] addr_lo,
    input  logic [7:0]         data,
    output logic               hit_key1,
    output logic               hit_key2,
    output logic               hit_prog,
    output logic               hit_erase,
    output logic               hit_conf
);

    logic at_a;
    logic at_b;

    always_comb begin
        at_a      = (addr_lo == UNLOCK_ADDR_A);
        at_b      = (addr_lo == UNLOCK_ADDR_B);
        hit_key1  = at_a && (data == KEY_FIRST);
        hit_key2  = at_b && (data == KEY_SECOND);
        hit_prog  = at_a && (data == OP_PROGRAM);
        hit_erase = at_a && (data == OP_ERASE);
        hit_conf  = (data == OP_SECT_CONF);
    end

endmodule

// File: rtl/nfc_busy_timer.sv
module nfc_busy_timer #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             active,
    output logic [CNT_W-1:0] idx,
    output logic             last
);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] idx;
        logic [CNT_W-1:0] len;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (start) begin
            t_d.active = 1'b1;
            t_d.idx    = '0;
            t_d.len    = len;
        end else if (t_q.active) begin
            if (t_q.idx == t_q.len - CNT_W'(1)) begin
                t_d.active = 1'b0;
            end else begin
                t_d.idx = t_q.idx + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign active = t_q.active;
    assign idx    = t_q.idx;
    assign last   = t_q.active && (t_q.idx == t_q.len - CNT_W'(1));

    // R8 / R9: the window never runs past its loaded length
    p_window_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.active |-> (t_q.idx < t_q.len));

endmodule

// File: rtl/nfc_array.sv
module nfc_array #(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/nor_flash_cmd.sv
module nor_flash_cmd
    import nfc_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int MEM_AW    = 13,
    parameter int SECT_AW   = 12,
    parameter int PROG_CYC  = 20,
    parameter int ERASE_CYC = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [7:0]        rdata
);

    localparam int SECT_BYTES = 1 << SECT_AW;
    localparam int ERASE_LEN  = (ERASE_CYC > SECT_BYTES) ? ERASE_CYC : SECT_BYTES;
    localparam int MAX_LEN    = (ERASE_LEN > PROG_CYC) ? ERASE_LEN : PROG_CYC;
    localparam int CNT_W      = $clog2(MAX_LEN + 1);
    localparam int SEL_W      = MEM_AW - SECT_AW;
    localparam int MATCH_W    = 15;

    typedef struct packed {
        nfc_state_e       state;
        logic [7:0]       rdata;
        logic [SEL_W-1:0] sect;
        logic             pbit7;
    } ctl_t;

    ctl_t r_d, r_q;

    logic hit_key1, hit_key2, hit_prog, hit_erase, hit_conf;

    logic              tmr_start;
    logic [CNT_W-1:0]  tmr_len;
    logic              tmr_active;
    logic [CNT_W-1:0]  tmr_idx;
    logic              tmr_last;

    logic              arr_we;
    logic [MEM_AW-1:0] arr_waddr;
    logic [7:0]        arr_wdata;
    logic [7:0]        arr_rdata;
    logic              erase_fill;
    logic              busy_now;

    nfc_unlock_decode #(
        .MATCH_W (MATCH_W)
    ) u_decode (
        .addr_lo   (addr[MATCH_W-1:0]),
        .data      (wdata),
        .hit_key1  (hit_key1),
        .hit_key2  (hit_key2),
        .hit_prog  (hit_prog),
        .hit_erase (hit_erase),
        .hit_conf  (hit_conf)
    );

    nfc_busy_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .len    (tmr_len),
        .active (tmr_active),
        .idx    (tmr_idx),
        .last   (tmr_last)
    );

    nfc_array #(
        .AW (MEM_AW),
        .DW (8)
    ) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (arr_wdata),
        .raddr (addr[MEM_AW-1:0]),
        .rdata (arr_rdata)
    );

    assign busy_now   = (r_q.state == ST_PGM_BUSY) || (r_q.state == ST_ERS_BUSY);
    assign erase_fill = (r_q.state == ST_ERS_BUSY) && (tmr_idx < CNT_W'(SECT_BYTES));

    always_comb begin
        r_d       = r_q;
        arr_we    = 1'b0;
        arr_waddr = addr[MEM_AW-1:0];
        arr_wdata = arr_rdata & wdata;
        tmr_start = 1'b0;
        tmr_len   = CNT_W'(PROG_CYC);

        case (r_q.state)
            ST_PGM_BUSY, ST_ERS_BUSY: begin
                if (rd_en) begin
                    r_d.rdata = (r_q.state == ST_PGM_BUSY) ? {~r_q.pbit7, 7'b0} : 8'h00;
                end
                if (erase_fill) begin
                    arr_we    = 1'b1;
                    arr_waddr = {r_q.sect, tmr_idx[SECT_AW-1:0]};
                    arr_wdata = 8'hFF;
                end
                if (tmr_last) begin
                    r_d.state = ST_IDLE;
                end
            end
            default: begin
                if (rd_en) begin
                    r_d.rdata = arr_rdata;
                    r_d.state = ST_IDLE;
                end else if (wr_en) begin
                    r_d.state = ST_IDLE;
                    case (r_q.state)
                        ST_IDLE: if (hit_key1) r_d.state = ST_U1;
                        ST_U1:   if (hit_key2) r_d.state = ST_U2;
                        ST_U2: begin
                            if (hit_prog)       r_d.state = ST_PGM_ARM;
                            else if (hit_erase) r_d.state = ST_E3;
                        end
                        ST_PGM_ARM: begin
                            arr_we    = 1'b1;
                            tmr_start = 1'b1;
                            r_d.pbit7 = wdata[7];
                            r_d.state = ST_PGM_BUSY;
                        end
                        ST_E3: if (hit_key1) r_d.state = ST_E4;
                        ST_E4: if (hit_key2) r_d.state = ST_E5;
                        ST_E5: begin
                            if (hit_conf) begin
                                tmr_start = 1'b1;
                                tmr_len   = CNT_W'(ERASE_LEN);
                                r_d.sect  = addr[MEM_AW-1:SECT_AW];
                                r_d.state = ST_ERS_BUSY;
                            end
                        end
                        default: r_d.state = ST_IDLE;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata = r_q.rdata;

    // R10: busy state and the timer window move together
    p_busy_timer_sync_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_now == tmr_active);

    // R8: program status shows the inverted bit being written
    p_prog_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_PGM_BUSY && rd_en) |=> (rdata == {~$past(r_q.pbit7), 7'b0}));

    // R9: erase status reads zero
    p_erase_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ERS_BUSY && rd_en) |=> (rdata == 8'h00));

    // R5: a read outside busy leaves the machine idle
    p_read_aborts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_now && rd_en) |=> (r_q.state == ST_IDLE));

    // R10: writes during busy do not disturb the operation
    p_busy_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_now && wr_en && !tmr_last) |=> (r_q.state == $past(r_q.state)) && $stable(r_q.sect));

    // R13: output holds without a read
    p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

// File: tb/nor_flash_cmd_tb.sv
module nor_flash_cmd_tb;

    localparam int PROG_CYC  = 20;
    localparam int ERASE_CYC = 5000;
    localparam int ELEN      = (ERASE_CYC > 4096) ? ERASE_CYC : 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [18:0] a = '0;
    logic [7:0]  d = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [7:0]  rdata;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    nor_flash_cmd #(
        .ADDR_W    (19),
        .MEM_AW    (13),
        .SECT_AW   (12),
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (a),
        .wdata (d),
        .wr_en (wr),
        .rd_en (rd),
        .rdata (rdata)
    );

    // behavioural reference
    logic [7:0] m_mem [0:8191];
    int         m_pos  = 0;
    int         m_busy = 0;
    bit         m_ers  = 1'b0;
    bit         m_b7   = 1'b0;
    logic [7:0] m_rd   = 8'h00;

    initial begin
        for (int i = 0; i < 8192; i++) m_mem[i] = 8'hFF;
    end

    always @(posedge clk) begin
        int idx;
        bit k1, k2;
        idx = int'(a[12:0]);
        k1  = (a[14:0] == 15'h5555) && (d == 8'hAA);
        k2  = (a[14:0] == 15'h2AAA) && (d == 8'h55);
        if (!rst_n) begin
            m_pos = 0; m_busy = 0; m_rd = 8'h00;
        end else if (m_busy > 0) begin
            if (rd) m_rd = m_ers ? 8'h00 : {~m_b7, 7'b0};
            m_busy--;
        end else if (rd) begin
            m_rd  = m_mem[idx];
            m_pos = 0;
        end else if (wr) begin
            if (m_pos == 0)      m_pos = k1 ? 1 : 0;
            else if (m_pos == 1) m_pos = k2 ? 2 : 0;
            else if (m_pos == 2) begin
                if (a[14:0] == 15'h5555 && d == 8'hA0)      m_pos = 3;
                else if (a[14:0] == 15'h5555 && d == 8'h80) m_pos = 4;
                else                                        m_pos = 0;
            end else if (m_pos == 3) begin
                m_mem[idx] = m_mem[idx] & d;
                m_b7 = d[7]; m_ers = 1'b0; m_busy = PROG_CYC; m_pos = 0;
            end else if (m_pos == 4) m_pos = k1 ? 5 : 0;
            else if (m_pos == 5)     m_pos = k2 ? 6 : 0;
            else begin
                if (d == 8'h30) begin
                    for (int j = 0; j < 4096; j++) m_mem[(idx & 32'h1000) + j] = 8'hFF;
                    m_ers = 1'b1; m_busy = ELEN;
                end
                m_pos = 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
        end
    endtask

    // R13: every cycle the registered output matches the reference
    always @(negedge clk) begin
        if (rst_n && !done) chk("R13 per-cycle model", rdata, m_rd);
    end

    task automatic wcyc(input logic [18:0] ad, input logic [7:0] dt);
        a = ad; d = dt; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rcyc(input logic [18:0] ad, output logic [7:0] v);
        a = ad; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        v = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic prog(input logic [18:0] ad, input logic [7:0] dt);
        wcyc(19'h05555, 8'hAA);
        wcyc(19'h02AAA, 8'h55);
        wcyc(19'h05555, 8'hA0);
        wcyc(ad, dt);
    endtask

    task automatic erase_hdr(input logic [18:0] ua, input logic [18:0] ub);
        wcyc(ua, 8'hAA);
        wcyc(ub, 8'h55);
        wcyc(ua, 8'h80);
        wcyc(ua, 8'hAA);
        wcyc(ub, 8'h55);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset rdata", rdata, 8'h00);

        // R4: erase sector 0 with nonzero low bits; R9 boundary
        erase_hdr(19'h05555, 19'h02AAA);
        wcyc(19'h00ABC, 8'h30);
        idle(2);
        rcyc(19'h00000, v); chk("R9 erase status early", v, 8'h00);
        idle(ELEN - 4);
        rcyc(19'h00000, v); chk("R9 erase status last busy cycle", v, 8'h00);
        rcyc(19'h00000, v); chk("R9 erase done data", v, 8'hFF);

        // R7: upper address bits ignored in unlock match; erase sector 1
        erase_hdr(19'h7D555, 19'h7AAAA);
        wcyc(19'h01FFF, 8'h30);
        idle(ELEN);
        rcyc(19'h01000, v); chk("R7 erase with high unlock bits", v, 8'hFF);
        rcyc(19'h00FFF, v); chk("R3 sector 0 top byte erased", v, 8'hFF);

        // R1, R8 boundary
        prog(19'h00010, 8'h5A);
        rcyc(19'h00010, v); chk("R8 program status bit7 inverted", v, 8'h80);
        idle(PROG_CYC - 2);
        rcyc(19'h00010, v); chk("R8 program status last busy cycle", v, 8'h80);
        rcyc(19'h00010, v); chk("R1 programmed value", v, 8'h5A);

        // R2: AND behaviour
        prog(19'h00010, 8'h0F);
        idle(PROG_CYC);
        rcyc(19'h00010, v); chk("R2 AND of old and new", v, 8'h0A);

        prog(19'h00020, 8'hC3);
        rcyc(19'h00020, v); chk("R8 status for bit7 set", v, 8'h00);
        idle(PROG_CYC);
        rcyc(19'h00020, v); chk("R1 second byte", v, 8'hC3);

        // R11: no unlock, no program
        wcyc(19'h00020, 8'h00);
        rcyc(19'h00020, v); chk("R11 write after program ignored", v, 8'hC3);
        wcyc(19'h00030, 8'h00);
        rcyc(19'h00030, v); chk("R12 idle plain write ignored", v, 8'hFF);

        // R6: wrong third cycle
        wcyc(19'h05555, 8'hAA);
        wcyc(19'h02AAA, 8'h55);
        wcyc(19'h05555, 8'h12);
        wcyc(19'h00040, 8'h00);
        rcyc(19'h00040, v); chk("R6 wrong command aborts", v, 8'hFF);
        // R6: repeated first key is a mismatch, not a restart
        wcyc(19'h05555, 8'hAA);
        wcyc(19'h05555, 8'hAA);
        wcyc(19'h02AAA, 8'h55);
        wcyc(19'h05555, 8'hA0);
        wcyc(19'h00041, 8'h00);
        rcyc(19'h00041, v); chk("R6 mismatch not taken as first cycle", v, 8'hFF);

        // R5: read after three cycles aborts
        wcyc(19'h05555, 8'hAA);
        wcyc(19'h02AAA, 8'h55);
        wcyc(19'h05555, 8'hA0);
        rcyc(19'h00050, v); chk("R5 read during sequence returns data", v, 8'hFF);
        wcyc(19'h00050, 8'h00);
        rcyc(19'h00050, v); chk("R5 read aborted program", v, 8'hFF);
        // R5: read inside erase sequence
        erase_hdr(19'h05555, 19'h02AAA);
        rcyc(19'h00010, v);
        wcyc(19'h00010, 8'h30);
        rcyc(19'h00010, v); chk("R5 read aborted erase", v, 8'h0A);

        // R10: writes during busy ignored
        prog(19'h00060, 8'h11);
        wcyc(19'h00060, 8'h00);
        prog(19'h00070, 8'h00);
        idle(PROG_CYC);
        rcyc(19'h00060, v); chk("R10 busy write ignored", v, 8'h11);
        rcyc(19'h00070, v); chk("R10 busy unlock ignored", v, 8'hFF);

        // R3: selective erase of sector 1
        prog(19'h01005, 8'h00); idle(PROG_CYC);
        prog(19'h00005, 8'h00); idle(PROG_CYC);
        erase_hdr(19'h05555, 19'h02AAA);
        wcyc(19'h01234, 8'h30);
        idle(ELEN);
        rcyc(19'h01005, v); chk("R3 target sector erased", v, 8'hFF);
        rcyc(19'h00005, v); chk("R3 other sector kept", v, 8'h00);
        rcyc(19'h00010, v); chk("R3 other sector kept 2", v, 8'h0A);

        // R13: hold without read
        idle(5);
        chk("R13 output holds", rdata, 8'h0A);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule